// File: doc/BRIEF.md
# Stimulus Artifact Template Calibration Controller

This controller learns the shape of a stimulation artifact that repeats on every stimulus. It then plays that shape back through a DAC into an analog subtraction node, so that the residue after subtraction stays small enough for the gain stages that follow. Each stimulus trigger opens one event window. The window steps through a sample memory, one entry per sample strobe, starting at entry zero. The ADC observes the subtraction node and the DAC drives it, and both use the same strobe.

The controller moves through three phases. In the first window after reset or after a relearn request, it drives mid-scale and records the raw ADC codes as the starting template. For a configured number of windows after that, it drives the template and adds each measured residue into the matching entry. From then on it replays the frozen template and does not modify it. Several templates are held in separate banks, and an external select picks the bank. A mode input reduces stored entries to 10-bit resolution.

Top module: `artifact_template_ctrl`

## Requirements
- R1: A trigger seen while no window is open starts a window at entry 0. Each sample strobe advances the window one entry, and the window closes after LEN strobes. While no window is open, the DAC code is mid-scale, 2048.
- R2: During the capture phase the DAC code is 2048, and each strobe stores the ADC code into the current entry.
- R3: During the refine phase the DAC code is the current entry, and each strobe writes entry + (adcCode − 2048) back into that entry.
- R4: Every stored value is clamped to the range 0 to 4095 and never wraps.
- R5: The phase output is 0 for capture, 1 for refine and 2 for replay. The capture window is followed by iterLimit refine windows, then replay. If iterLimit is 0, replay follows capture directly. iterDone counts the refine windows that have finished.
- R6: During the replay phase the DAC code is the current entry, and the template is not changed by anything on the ADC input.
- R7: While coarseMode is 1, every stored value has bits [1:0] cleared.
- R8: A trigger that arrives while a window is open is ignored: the open window carries on unchanged. It sets overlapErr, which stays set until reset or recal.
- R9: A recal pulse closes any open window and returns the controller to capture with iterDone at 0 and overlapErr cleared.
- R10: The bank is taken from bankSel when a window opens and held for the whole window. Each bank keeps its own template, so selecting a bank replays that bank's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Stimulus event; opens a window |
| recal | input | 1 | Relearn request; returns to capture |
| sampleEn | input | 1 | Shared ADC/DAC sample strobe |
| coarseMode | input | 1 | 1: store at 10-bit resolution |
| bankSel | input | BW | Template bank for the next window |
| iterLimit | input | ITER_W | Number of refine windows |
| adcCode | input | DW | Subtraction-node sample, offset binary |
| dacCode | output | DW | Template drive, offset binary |
| phase | output | 2 | 0 capture, 1 refine, 2 replay |
| iterDone | output | ITER_W | Completed refine windows |
| overlapErr | output | 1 | Sticky overlapping-trigger flag |

## Verification
The assertions rely on iterLimit changing only in the same cycle as a recal pulse. The bench keeps to this by setting a new limit only while it pulses recal. The residue check relies on a zero residue being presented at full resolution, so the bench does not switch coarseMode during a training sequence. The bench models the analog node as an ideal subtraction with a 3/4 gain mismatch, which makes refinement go through several windows. It places artifact samples at both code limits to drive the clamp.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [1:0] {
    PH_CAPTURE = 2'd0,
    PH_REFINE  = 2'd1,
    PH_REPLAY  = 2'd2
  } phase_e;

  typedef struct packed {
    logic writeEn;
    logic captureRaw;
    logic driveTemplate;
  } strobe_t;
endpackage

// File: rtl/atc_ctrl.sv
module atc_ctrl
  import atc_pkg::*;
#(
  parameter int LEN       = 32,
  parameter int NUM_BANKS = 4,
  parameter int ITER_W    = 8,
  localparam int AW = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigger,
  input  logic              recal,
  input  logic              sampleEn,
  input  logic [BW-1:0]     bankSel,
  input  logic [ITER_W-1:0] iterLimit,
  output strobe_t           strobes,
  output logic [AW-1:0]     addr,
  output logic [BW-1:0]     bankQ,
  output phase_e            phase,
  output logic [ITER_W-1:0] iterDone,
  output logic              overlapErr
);
  logic active;
  logic tick;
  logic lastSample;

  assign tick       = active & sampleEn;
  assign lastSample = (addr == AW'(LEN - 1));

  always_comb begin
    strobes.writeEn       = tick && (phase != PH_REPLAY);
    strobes.captureRaw    = (phase == PH_CAPTURE);
    strobes.driveTemplate = active && (phase != PH_CAPTURE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_CAPTURE;
      iterDone   <= '0;
      active     <= 1'b0;
      addr       <= '0;
      bankQ      <= '0;
      overlapErr <= 1'b0;
    end else if (recal) begin
      phase      <= PH_CAPTURE;
      iterDone   <= '0;
      active     <= 1'b0;
      addr       <= '0;
      overlapErr <= 1'b0;
    end else begin
      if (trigger) begin
        if (active) begin
          overlapErr <= 1'b1;
        end else begin
          active <= 1'b1;
          addr   <= '0;
          bankQ  <= bankSel;
        end
      end
      if (tick) begin
        if (lastSample) begin
          active <= 1'b0;
          addr   <= '0;
          unique case (phase)
            PH_CAPTURE: phase <= (iterLimit == '0) ? PH_REPLAY : PH_REFINE;
            PH_REFINE: begin
              iterDone <= iterDone + ITER_W'(1);
              if ((iterDone + ITER_W'(1)) >= iterLimit) phase <= PH_REPLAY;
            end
            default: phase <= PH_REPLAY;
          endcase
        end else begin
          addr <= addr + AW'(1);
        end
      end
    end
  end

  assert_start_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !active && !recal) |=> (active && addr == '0));

  assert_iter_bound_R5: assert property (@(posedge clk) disable iff (!rstN || recal)
    iterDone <= iterLimit);

  assert_replay_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_REPLAY && !recal) |=> (phase == PH_REPLAY));

  assert_overlap_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overlapErr && !recal) |=> overlapErr);

  assert_recal_R9: assert property (@(posedge clk) disable iff (!rstN)
    recal |=> (phase == PH_CAPTURE && !active && iterDone == '0 && !overlapErr));
endmodule

// File: rtl/atc_datapath.sv
module atc_datapath
  import atc_pkg::*;
#(
  parameter int DW         = 12,
  parameter int LEN        = 32,
  parameter int NUM_BANKS  = 4,
  parameter int TRUNC_BITS = 2,
  localparam int AW    = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int BW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int DEPTH = LEN * NUM_BANKS,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bank,
  input  logic          coarseMode,
  input  logic [DW-1:0] adcCode,
  output logic [DW-1:0] dacCode
);
  localparam logic [DW-1:0] MID    = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] MAXC   = '1;
  localparam logic [DW-1:0] KEEP_C = MAXC << TRUNC_BITS;

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;
  logic [DW-1:0] rdVal;
  logic signed [DW+1:0] sum;
  logic [DW-1:0] satVal;
  logic [DW-1:0] newVal;
  logic [DW-1:0] wrVal;

  assign idx   = IW'(bank) * IW'(LEN) + IW'(addr);
  assign rdVal = mem[idx];
  assign dacCode = strobes.driveTemplate ? rdVal : MID;

  always_comb begin
    sum = $signed({2'b00, rdVal}) + $signed({2'b00, adcCode}) - $signed({2'b00, MID});
    if (sum < 0)                               satVal = '0;
    else if (sum > $signed({2'b00, MAXC}))     satVal = MAXC;
    else                                       satVal = sum[DW-1:0];
    newVal = strobes.captureRaw ? adcCode : satVal;
    wrVal  = coarseMode ? (newVal & KEEP_C) : newVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= MID;
    end else if (strobes.writeEn) begin
      mem[idx] <= wrVal;
    end
  end

  assert_zero_residue_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeEn && !strobes.captureRaw && !coarseMode && adcCode == MID)
      |=> (mem[$past(idx)] == $past(rdVal)));

  assert_coarse_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeEn && coarseMode) |=> (mem[$past(idx)][TRUNC_BITS-1:0] == '0));
endmodule

// File: rtl/artifact_template_ctrl.sv
module artifact_template_ctrl
  import atc_pkg::*;
#(
  parameter int DW         = 12,
  parameter int LEN        = 32,
  parameter int NUM_BANKS  = 4,
  parameter int ITER_W     = 8,
  parameter int TRUNC_BITS = 2,
  localparam int AW = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigger,
  input  logic              recal,
  input  logic              sampleEn,
  input  logic              coarseMode,
  input  logic [BW-1:0]     bankSel,
  input  logic [ITER_W-1:0] iterLimit,
  input  logic [DW-1:0]     adcCode,
  output logic [DW-1:0]     dacCode,
  output logic [1:0]        phase,
  output logic [ITER_W-1:0] iterDone,
  output logic              overlapErr
);
  strobe_t       strobes;
  logic [AW-1:0] addr;
  logic [BW-1:0] bankQ;
  phase_e        phaseQ;

  atc_ctrl #(.LEN(LEN), .NUM_BANKS(NUM_BANKS), .ITER_W(ITER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .recal(recal),
    .sampleEn(sampleEn), .bankSel(bankSel), .iterLimit(iterLimit),
    .strobes(strobes), .addr(addr), .bankQ(bankQ), .phase(phaseQ),
    .iterDone(iterDone), .overlapErr(overlapErr)
  );

  atc_datapath #(.DW(DW), .LEN(LEN), .NUM_BANKS(NUM_BANKS), .TRUNC_BITS(TRUNC_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .bank(bankQ),
    .coarseMode(coarseMode), .adcCode(adcCode), .dacCode(dacCode)
  );

  assign phase = phaseQ;
endmodule

// File: tb/artifact_template_ctrl_tb.sv
module artifact_template_ctrl_tb;
  localparam int LEN = 8;
  localparam int MID = 2048;
  localparam int CAP = 0, REF = 1, REP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0, recal = 1'b0, sampleEn = 1'b0, coarseMode = 1'b0;
  logic [0:0]  bankSel = 1'b0;
  logic [3:0]  iterLimit = 4'd3;
  logic [11:0] adcCode = 12'd2048;
  logic [11:0] dacCode;
  logic [1:0]  phase;
  logic [3:0]  iterDone;
  logic        overlapErr;

  int compared = 0, mismatched = 0;
  int tmpl [2][LEN];
  int lastDac [LEN];
  int mPhase = CAP, mIter = 0, mLimit = 3, mOv = 0;

  always #2.5 clk = ~clk;

  artifact_template_ctrl #(.DW(12), .LEN(LEN), .NUM_BANKS(2), .ITER_W(4), .TRUNC_BITS(2)) u_dut (
    .clk(clk), .rstN(rstN), .trigger(trigger), .recal(recal), .sampleEn(sampleEn),
    .coarseMode(coarseMode), .bankSel(bankSel), .iterLimit(iterLimit), .adcCode(adcCode),
    .dacCode(dacCode), .phase(phase), .iterDone(iterDone), .overlapErr(overlapErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int art(input int pat, input int k);
    if (pat == 0) return (k == 0) ? 4095 : (k == 1) ? 0 : (k * 613 + 300) % 4096;
    if (pat == 1) return 3000 - k * 250;
    return (k * 977 + 123) % 4096;
  endfunction

  // ideal subtraction node with a 3/4 gain mismatch
  function automatic int analog(input int a, input int dac);
    int v;
    v = a - ((dac - MID) * 3) / 4;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic int store(input int v);
    int s;
    s = (v < 0) ? 0 : (v > 4095) ? 4095 : v;
    return coarseMode ? (s & ~3) : s;
  endfunction

  task automatic statusChk(input string tag);
    chk({tag, " phase"}, int'(phase), mPhase);
    chk({tag, " iterDone"}, int'(iterDone), mIter);
    chk({tag, " overlapErr"}, int'(overlapErr), mOv);
    chk({tag, " idle dac"}, int'(dacCode), MID);
  endtask

  // called at a negedge; opens one window and runs LEN strobes
  task automatic doWindow(input int pat, input int ovAt, input int flipAt,
                          input int recalAt, input int newLimit, input string rtag);
    int b, a, exp;
    string t;
    b = int'(bankSel);
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    for (int k = 0; k < LEN; k++) begin
      if (k == ovAt) begin
        trigger = 1'b1; @(negedge clk); trigger = 1'b0; mOv = 1;
        chk("R8 overlap flag", int'(overlapErr), 1);
      end
      if (k == flipAt) bankSel = ~bankSel;
      if (k == recalAt) begin
        recal = 1'b1; iterLimit = 4'(newLimit); @(negedge clk); recal = 1'b0;
        mPhase = CAP; mIter = 0; mOv = 0; mLimit = newLimit;
        statusChk("R9 recal abort");
        return;
      end
      exp = (mPhase == CAP) ? MID : tmpl[b][k];
      t = (mPhase == CAP) ? "R2 capture dac" : (mPhase == REF) ? "R3 refine dac" : rtag;
      chk(t, int'(dacCode), exp);
      lastDac[k] = int'(dacCode);
      a = analog(art(pat, k), exp);
      adcCode = 12'(a); sampleEn = 1'b1; @(negedge clk); sampleEn = 1'b0;
      if (mPhase == CAP) tmpl[b][k] = store(a);
      else if (mPhase == REF) tmpl[b][k] = store(tmpl[b][k] + a - MID);
      @(negedge clk);
    end
    if (mPhase == CAP) mPhase = (mLimit == 0) ? REP : REF;
    else if (mPhase == REF) begin
      mIter++;
      if (mIter >= mLimit) mPhase = REP;
    end
    statusChk("R1/R5 window end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int k = 0; k < LEN; k++) tmpl[b][k] = MID;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    statusChk("reset R5");

    // R1: strobes without a window do nothing
    sampleEn = 1'b1; adcCode = 12'd100; repeat (3) @(negedge clk); sampleEn = 1'b0;
    statusChk("R1 no window");

    // bank 0: capture + 3 refine windows (R2, R3, R4, R5)
    doWindow(0, -1, -1, -1, 0, "R6");
    for (int i = 0; i < 3; i++) doWindow(0, -1, -1, -1, 0, "R6");
    chk("R5 replay reached", int'(phase), REP);

    // replay with varying ADC input leaves the template unchanged (R6, R4)
    doWindow(1, -1, -1, -1, 0, "R6 replay dac");
    doWindow(2, -1, -1, -1, 0, "R6 replay repeat");
    chk("R4 clamp high", lastDac[0], 4095);
    chk("R4 clamp low", lastDac[1], 0);

    // overlapping trigger in the middle of a replay window (R8)
    doWindow(2, 3, -1, -1, 0, "R8 window unaffected");
    chk("R8 sticky", int'(overlapErr), 1);

    // relearn on bank 1 at 10-bit resolution, 2 refine windows (R9, R7, R10)
    @(negedge clk);
    recal = 1'b1; iterLimit = 4'd2; bankSel = 1'b1; coarseMode = 1'b1;
    @(negedge clk); recal = 1'b0;
    mPhase = CAP; mIter = 0; mOv = 0; mLimit = 2;
    statusChk("R9 recal");
    doWindow(1, -1, 4, -1, 0, "R10");
    bankSel = 1'b1;
    doWindow(1, -1, 2, -1, 0, "R10");
    bankSel = 1'b1;
    doWindow(1, -1, -1, -1, 0, "R10");
    chk("R5 replay after 2", int'(phase), REP);

    doWindow(0, -1, -1, -1, 0, "R10 bank1 replay");
    for (int k = 0; k < LEN; k++) chk("R7 coarse lsbs", lastDac[k] & 3, 0);
    bankSel = 1'b0;
    doWindow(0, -1, -1, -1, 0, "R10 bank0 replay");
    chk("R10 bank0 kept", lastDac[0], 4095);

    // recal aborts an open window, with zero refine windows next (R9, R5)
    coarseMode = 1'b0;
    doWindow(0, -1, -1, 3, 0, "R9");
    doWindow(1, -1, -1, -1, 0, "R5");
    chk("R5 direct replay", int'(phase), REP);
    doWindow(2, -1, -1, -1, 0, "R5 replay captured");
    chk("R2 raw stored", lastDac[2], art(1, 2));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule